// File: doc/BRIEF.md
# Quadrature DDS Upconversion Modulator

This block turns a pair of baseband samples into one real intermediate-frequency sample on every system clock. It contains a numerically controlled oscillator: a phase accumulator advances by a programmable tuning word each clock. The top bits of the accumulator address a folded quarter-wave sine table, which gives a cosine carrier and a sine carrier from the same phase. The in-phase sample is multiplied by the cosine carrier and the quadrature sample by the sine carrier. The two products are then added or subtracted, rounded, and saturated to a 12-bit two's-complement output.

The sideband control picks whether the products are added or subtracted, and so which sideband is produced. A tone mode ignores the baseband inputs and sends the cosine carrier straight to the output, which makes the block a plain frequency synthesizer. The tuning word is loaded through a one-cycle write strobe. A synchronous clear input restarts the phase at zero. Changing the tuning word never resets the phase, so a frequency step keeps the carrier phase continuous.

Top module: `qdds_upconv`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, the tuning word and every pipeline stage go to zero, so `if_out` reads 0 after reset.
- R2: For a 10-bit phase p (accumulator bits 31:22), the sine carrier is round(2047·sin(2π(p+0.5)/1024)), rounded away from zero at halves. The cosine carrier is the sine carrier at (p+256) mod 1024.
- R3: On each clock edge without reset or clear, the accumulator advances by the stored tuning word, modulo 2^32.
- R4: Outside tone mode, the output is floor((I·cos + S·Q·sin + 1024)/2048), saturated. S is +1 when `sideband_sub` is 0 and −1 when it is 1. The carriers are the ones for the phase held before the edge that captures I and Q.
- R5: When `tone_mode` is 1, the output equals the cosine carrier of that sample's phase, and `i_in` and `q_in` have no effect.
- R6: With `tw_wr_en` high at an edge, the tuning word takes `tw_wr_data`, and the accumulator uses the new word from the next edge on, with no phase jump. With `tw_wr_en` low, `tw_wr_data` is ignored.
- R7: With `phase_clr` high at an edge, the accumulator becomes 0. This takes priority over the increment.
- R8: Any result above 2047 is output as 2047, and any result below −2048 as −2048.
- R9: The sample captured at edge e appears on `if_out` after edge e+2. One new output is produced every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tw_wr_en | input | 1 | Tuning word write strobe |
| tw_wr_data | input | 32 | Tuning word value to load |
| phase_clr | input | 1 | Synchronous clear of the phase accumulator |
| sideband_sub | input | 1 | 0: add the products, 1: subtract the Q product |
| tone_mode | input | 1 | 1: output the cosine carrier only |
| i_in | input | 12 | In-phase sample, two's complement |
| q_in | input | 12 | Quadrature sample, two's complement |
| if_out | output | 12 | Saturated intermediate-frequency sample |

## Verification
The assertions check the following on every cycle:
- the accumulator step, including the priority of clear over the increment;
- loading and holding of the tuning word;
- the post-reset output;
- the path that carries the cosine carrier to the output in tone mode.

Only the bench's scenarios can show the rest. These are the exact carrier values, the rounding and the sideband sign of the mixed output, and saturation at both rails. They also cover phase continuity across a mid-stream frequency change and the two-edge alignment between samples and carriers. The bench compares each output against a model that tracks the phase.

// File: rtl/qdds_pkg.sv
package qdds_pkg;

    localparam int SAMPLE_W    = 12;
    localparam int PROD_W      = 2 * SAMPLE_W;
    localparam int SUM_W       = PROD_W + 1;
    localparam int FRAC_SHIFT  = SAMPLE_W - 1;
    localparam int CARRIER_AMP = (1 << (SAMPLE_W - 1)) - 1;
    localparam real QDDS_PI    = 3.14159265358979323846;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [PROD_W-1:0]   product_t;
    typedef logic signed [SUM_W-1:0]    wide_t;

    // stage-1 payload: captured samples and controls
    typedef struct packed {
        sample_t i_s;
        sample_t q_s;
        logic    sub;
        logic    tone;
    } front_t;

    // stage-1 carriers for the captured phase
    typedef struct packed {
        sample_t cos_v;
        sample_t sin_v;
    } carrier_t;

    // stage-2 payload: products and delayed controls
    typedef struct packed {
        product_t p_i;
        product_t p_q;
        sample_t  tone_v;
        logic     sub;
        logic     tone;
    } prod_t;

    // quarter-wave entry k of 2^idx_w, centred at half-step offsets
    function automatic sample_t quarter_sine(input int k, input int idx_w);
        real ang;
        real v;
        ang = (real'(k) + 0.5) * QDDS_PI / (2.0 * real'(1 << idx_w));
        v   = real'(CARRIER_AMP) * $sin(ang);
        return sample_t'($rtoi(v + 0.5));
    endfunction

    function automatic sample_t clamp_sample(input wide_t x);
        wide_t hi;
        wide_t lo;
        hi = wide_t'(CARRIER_AMP);
        lo = -hi - wide_t'(1);
        if (x > hi)      return sample_t'(CARRIER_AMP);
        else if (x < lo) return sample_t'(-CARRIER_AMP - 1);
        else             return sample_t'(x);
    endfunction

endpackage

// File: rtl/qdds_phase_acc.sv
module qdds_phase_acc
    import qdds_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ACC_W-1:0]   wr_data,
    input  logic               clr,
    output logic [ACC_W-1:0]   acc,
    output logic [ACC_W-1:0]   ftw,
    output logic [PHASE_W-1:0] phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ftw <= '0;
        end else if (wr_en) begin
            ftw <= wr_data;
        end
    end

    // increment with the word stored before this edge: no phase jump on reload
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else begin
            acc <= acc + ftw;
        end
    end

    assign phase = acc[ACC_W-1 -: PHASE_W];

endmodule

// File: rtl/qdds_quarter_lut.sv
module qdds_quarter_lut
    import qdds_pkg::*;
#(
    parameter int PHASE_W    = 10,
    parameter int QUAD_SHIFT = 0
) (
    input  logic [PHASE_W-1:0] phase,
    output sample_t            value
);

    localparam int IDX_W = PHASE_W - 2;
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [PHASE_W-1:0] OFFS = PHASE_W'(QUAD_SHIFT) << IDX_W;

    sample_t tbl [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
        assign tbl[k] = quarter_sine(k, IDX_W);
    end

    logic [PHASE_W-1:0] p;
    logic [1:0]         quad;
    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   addr;
    sample_t            mag;

    always_comb begin
        p     = phase + OFFS;
        quad  = p[PHASE_W-1 -: 2];
        idx   = p[IDX_W-1:0];
        addr  = quad[0] ? ~idx : idx;
        mag   = tbl[addr];
        value = quad[1] ? -mag : mag;
    end

endmodule

// File: rtl/qdds_mixer.sv
module qdds_mixer
    import qdds_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  front_t   f1,
    input  carrier_t c1,
    output sample_t  if_out
);

    localparam wide_t RND = wide_t'(1) <<< (FRAC_SHIFT - 1);

    prod_t   p2;
    wide_t   ext_i;
    wide_t   ext_q;
    wide_t   sum;
    wide_t   scaled;
    sample_t mixed;

    always_ff @(posedge clk) begin
        if (rst) begin
            p2 <= '0;
        end else begin
            p2.p_i    <= product_t'(f1.i_s) * product_t'(c1.cos_v);
            p2.p_q    <= product_t'(f1.q_s) * product_t'(c1.sin_v);
            p2.tone_v <= c1.cos_v;
            p2.sub    <= f1.sub;
            p2.tone   <= f1.tone;
        end
    end

    always_comb begin
        ext_i  = wide_t'(p2.p_i);
        ext_q  = wide_t'(p2.p_q);
        sum    = p2.sub ? (ext_i - ext_q) : (ext_i + ext_q);
        scaled = (sum + RND) >>> FRAC_SHIFT;
        mixed  = clamp_sample(scaled);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            if_out <= '0;
        end else begin
            if_out <= p2.tone ? p2.tone_v : mixed;
        end
    end

endmodule

// File: rtl/qdds_upconv.sv
module qdds_upconv
    import qdds_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tw_wr_en,
    input  logic [ACC_W-1:0] tw_wr_data,
    input  logic             phase_clr,
    input  logic             sideband_sub,
    input  logic             tone_mode,
    input  logic [11:0]      i_in,
    input  logic [11:0]      q_in,
    output logic [11:0]      if_out
);

    logic [ACC_W-1:0]   acc_q;
    logic [ACC_W-1:0]   ftw_q;
    logic [PHASE_W-1:0] phase;
    sample_t            lut_val [2];
    front_t             f1;
    carrier_t           c1;
    sample_t            mix_out;

    qdds_phase_acc #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tw_wr_en),
        .wr_data (tw_wr_data),
        .clr     (phase_clr),
        .acc     (acc_q),
        .ftw     (ftw_q),
        .phase   (phase)
    );

    // g = 0: sine, g = 1: cosine (quarter-turn ahead)
    for (genvar g = 0; g < 2; g++) begin : g_carrier
        qdds_quarter_lut #(.PHASE_W(PHASE_W), .QUAD_SHIFT(g)) u_lut (
            .phase (phase),
            .value (lut_val[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f1 <= '0;
            c1 <= '0;
        end else begin
            f1.i_s  <= sample_t'(i_in);
            f1.q_s  <= sample_t'(q_in);
            f1.sub  <= sideband_sub;
            f1.tone <= tone_mode;
            c1.cos_v <= lut_val[1];
            c1.sin_v <= lut_val[0];
        end
    end

    qdds_mixer u_mix (
        .clk    (clk),
        .rst    (rst),
        .f1     (f1),
        .c1     (c1),
        .if_out (mix_out)
    );

    assign if_out = mix_out;

endmodule

// File: rtl/qdds_upconv_chk.sv
module qdds_upconv_chk
    import qdds_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tw_wr_en,
    input logic [ACC_W-1:0] tw_wr_data,
    input logic             phase_clr,
    input logic             tone_mode,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] ftw,
    input carrier_t         c1,
    input logic [11:0]      if_out
);

    assert_reset_out_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> if_out == 12'd0);

    assert_acc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(phase_clr)) |-> acc == $past(acc) + $past(ftw));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(phase_clr) |-> acc == '0);

    assert_ftw_load_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tw_wr_en)) |-> ftw == $past(tw_wr_data));

    assert_ftw_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tw_wr_en)) |-> $stable(ftw));

    assert_tone_path_R5: assert property (@(posedge clk) disable iff (rst)
        $past(tone_mode, 3) |-> if_out == $past(c1.cos_v, 2));

endmodule

bind qdds_upconv qdds_upconv_chk #(.ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tw_wr_en   (tw_wr_en),
    .tw_wr_data (tw_wr_data),
    .phase_clr  (phase_clr),
    .tone_mode  (tone_mode),
    .acc        (acc_q),
    .ftw        (ftw_q),
    .c1         (c1),
    .if_out     (if_out)
);

// File: tb/sim_qdds_upconv.sv
module sim_qdds_upconv;

    localparam real PI = 3.14159265358979323846;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tw_wr_en = 1'b0;
    logic [31:0] tw_wr_data = '0;
    logic        phase_clr = 1'b0;
    logic        sideband_sub = 1'b0;
    logic        tone_mode = 1'b0;
    logic [11:0] i_in = '0;
    logic [11:0] q_in = '0;
    logic [11:0] if_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] acc_m = '0;
    logic [31:0] ftw_m = '0;
    int h0 = 0, h1 = 0, h2 = 0;

    always #2 clk = ~clk;

    qdds_upconv u0 (
        .clk(clk), .rst(rst), .tw_wr_en(tw_wr_en), .tw_wr_data(tw_wr_data),
        .phase_clr(phase_clr), .sideband_sub(sideband_sub), .tone_mode(tone_mode),
        .i_in(i_in), .q_in(q_in), .if_out(if_out)
    );

    function automatic int carrier(input int p);
        real v;
        v = 2047.0 * $sin(2.0 * PI * (real'(p) + 0.5) / 1024.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(-v + 0.5);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one clock: drive, predict, then compare the output of two samples back
    task automatic step(input int iv, input int qv, input bit wr, input logic [31:0] wd,
                        input bit clr, input bit sub, input bit tone, input string tag);
        int p, c, s, e;
        longint tot, r;
        @(negedge clk);
        i_in = 12'(iv); q_in = 12'(qv);
        tw_wr_en = wr; tw_wr_data = wd; phase_clr = clr;
        sideband_sub = sub; tone_mode = tone;
        p = int'(acc_m[31:22]);
        c = carrier((p + 256) % 1024);
        s = carrier(p);
        if (tone) begin
            e = c;
        end else begin
            tot = longint'(iv) * c + (sub ? -1 : 1) * longint'(qv) * s;
            r = (tot + 1024) >>> 11;
            if (r > 2047) r = 2047;
            if (r < -2048) r = -2048;
            e = int'(r);
        end
        acc_m = clr ? 32'd0 : acc_m + ftw_m;
        if (wr) ftw_m = wd;
        h2 = h1; h1 = h0; h0 = e;
        @(posedge clk); #1;
        check(tag, int'($signed(if_out)), h2);
    endtask

    task automatic flush(input string tag);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic t_reset;
        #1;
        check("R1 reset output", int'($signed(if_out)), 0);
        step(100, 100, 0, 0, 0, 0, 0, "R1 after reset");
        step(-100, 5, 0, 0, 0, 0, 0, "R1 after reset");
    endtask

    task automatic t_modulate_add;
        step(0, 0, 1, 32'h0123_4567, 1, 0, 0, "R3 R7 setup");
        for (int k = 0; k < 40; k++)
            step(((k * 317) % 4096) - 2048, ((k * 911 + 55) % 4096) - 2048,
                 0, 0, 0, 0, 0, "R4 R9 R3 add");
        flush("R9 drain");
    endtask

    task automatic t_modulate_sub;
        step(0, 0, 1, 32'h0377_1000, 1, 1, 0, "R7 setup");
        for (int k = 0; k < 30; k++)
            step(((k * 523) % 3000) - 1500, 1200 - ((k * 211) % 2400),
                 0, 0, 0, 1, 0, "R4 sub");
        flush("R4 drain");
    endtask

    task automatic t_tone;
        step(0, 0, 1, 32'h00A0_0001, 1, 0, 1, "R5 setup");
        for (int k = 0; k < 300; k++)
            step(2047 - k, -2048 + k, 0, 0, 0, k % 2, 1, "R5 R2 tone");
        flush("R5 drain");
    endtask

    task automatic t_retune;
        step(0, 0, 1, 32'h0200_0000, 1, 0, 0, "R6 setup");
        for (int k = 0; k < 10; k++) step(1500, -700, 0, 0, 0, 0, 0, "R6 first word");
        step(1500, -700, 1, 32'h0733_3333, 0, 0, 0, "R6 load");
        for (int k = 0; k < 10; k++) step(1500, -700, 0, 32'hFFFF_0000, 0, 0, 0, "R6 ignored data");
        step(900, 900, 1, 32'hF000_0000, 0, 0, 0, "R6 negative word");
        for (int k = 0; k < 10; k++) step(900, 900, 0, 32'h1234_5678, 0, 0, 0, "R6 R3 wrap");
        flush("R6 drain");
    endtask

    task automatic t_clear;
        step(0, 0, 1, 32'h0555_5555, 0, 0, 0, "R7 setup");
        for (int k = 0; k < 7; k++) step(1800, 300, 0, 0, 0, 0, 0, "R7 run");
        step(1800, 300, 0, 0, 1, 0, 0, "R7 clear");
        step(1800, 300, 0, 0, 1, 0, 0, "R7 clear twice");
        for (int k = 0; k < 6; k++) step(1800, 300, 0, 0, 0, 0, 0, "R7 restart");
        flush("R7 drain");
    endtask

    task automatic t_saturate;
        step(0, 0, 1, 32'h2000_0000, 1, 0, 0, "R8 setup");
        step(0, 0, 1, 32'h0000_0000, 0, 0, 0, "R8 setup");
        step(2047, 2047, 0, 0, 0, 0, 0, "R8 high rail");
        step(-2048, -2048, 0, 0, 0, 0, 0, "R8 low rail");
        step(2047, -2048, 0, 0, 0, 1, 0, "R8 high rail sub");
        step(-2048, 2047, 0, 0, 0, 1, 0, "R8 low rail sub");
        step(1, 0, 0, 0, 0, 0, 0, "R4 rounding small");
        step(-1, 0, 0, 0, 0, 0, 0, "R4 rounding small neg");
        step(1000, -1000, 0, 0, 0, 0, 0, "R4 cancel");
        flush("R8 drain");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_modulate_add();
        t_modulate_sub();
        t_tone();
        t_retune();
        t_clear();
        t_saturate();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule